// File: doc/BRIEF.md
# MDIO Management Frame Engine with Status Polling

This block connects a host register bus to the two-wire management interface of external Ethernet PHYs. It has three ways of working. In frame mode the host writes one 32-bit frame word. The engine adds a preamble of 32 ones, shifts the frame out MSB first on MDC/MDIO, and then reports completion and any read data back in the same word. In polling mode the engine reads one chosen PHY register over and over. It keeps the last value it read, collects a set of bits that have changed since the last clear, and raises a maskable interrupt level. In bit-bang mode three one-bit host registers drive the clock, the data and the output enable straight onto the pins.

Two PHY ports share MDC. A select bit picks which port's MDIO input is sampled and which port's output enable may be driven. The MDC half-period is a parameter measured in system clocks. Registers are addressed by a 3-bit index: 0 frame, 1 configuration, 2 interrupt mask, 3 basic/status, 4 bit-bang clock, 5 bit-bang data, 6 bit-bang output enable.

Top module: `mdio_mgmt`

## Requirements
- R1: Frame word layout: data [15:0], turnaround [17:16], register address [22:18], PHY address [27:23], opcode [29:28], start [31:30]. A frame with opcode 2'b10 is a read. After the 32-one preamble its header goes out MSB first, and on completion the 16 sampled data bits land in frame bits [15:0].
- R2: For any other opcode, such as 2'b01 for a write, the engine drives all 64 bit times. The 32 frame bits go out exactly as stored, MSB first, after the preamble.
- R3: Writing the frame register clears bit 16, and bit 16 stays 0 while the transfer is pending or running. The engine sets bit 16 to 1 when the last bit time ends. After reset the frame register reads 32'h0001_0000.
- R4: MDC has a period of 2*CLK_HALF clocks: low for the first half of each bit time, high for the second half. MDC stays low while the engine is idle and bit-bang mode is off.
- R5: During a read the output enable drops at the first turnaround bit (frame bit 46 counted from the start of the preamble) and stays low through the 16 data bits.
- R6: The configuration register holds port select in bit 0, poll enable in bit 1, bit-bang enable in bit 2, poll register address in [7:3] and poll PHY address in [14:10]. With poll enable set, the engine issues read frames back to back to that PHY and register.
- R7: Basic/status reads as {last polled value[31:16], changed bits[15:0]}. The first poll after poll enable loads the value and sets no changed bits. Each later poll ORs (old XOR new) into the changed bits.
- R8: The interrupt level is high when any changed bit has its mask bit at 0. A mask bit of 1 hides that bit. The mask resets to 16'hFFFF.
- R9: Reading basic/status clears the changed bits, and the interrupt level drops on the next cycle.
- R10: With bit-bang enable set, MDC, MDIO-out and the selected port's output enable follow the bit-bang registers (bit 0 of each). Reading address 5 returns the selected port's MDIO input in bit 0. Host frames and polls are held and do not start.
- R11: A host frame written while a poll read is running starts only after that poll read ends. When both are waiting and the engine is idle, the host frame goes first.
- R12: Port select chooses which MDIO input bit is sampled and which output-enable bit may be driven. At most one output-enable bit is ever high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read side effects) |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| mdc | output | 1 | Management clock to both ports |
| mdio_out | output | 1 | Management data driven by the block |
| mdio_oe | output | 2 | Per-port output enable for mdio_out |
| mdio_in | input | 2 | Per-port management data input |
| irq | output | 1 | Unmasked change interrupt level |

## Verification
A bench PHY responder decodes each 64-bit frame on the MDC edges, so write frames, read frames and poll frames can be told apart by their captured headers. Read data comes back from a changeable register value. A second read with port 1 selected and port 0 tied low shows which input is sampled. Poll runs first with a constant PHY value, which must give no changed bits, and then with a known XOR pattern. That pattern is viewed under a full mask and a partial mask to separate change collection from interrupt masking. A host write placed in the middle of a poll frame, and a host frame left pending under bit-bang, show the ordering and the suspension rules.

// File: rtl/mdio_pkg.sv
// Shared register indices and frame helpers for the MDIO management block.
// Assumes a 32-bit frame word with the field layout given in the brief.
package mdio_pkg;
    typedef enum logic [2:0] {
        RA_FRAME = 3'd0,
        RA_CFG   = 3'd1,
        RA_MASK  = 3'd2,
        RA_STAT  = 3'd3,
        RA_BBCLK = 3'd4,
        RA_BBDAT = 3'd5,
        RA_BBOE  = 3'd6
    } reg_idx_e;

    localparam logic [31:0] FRAME_IDLE = 32'h0001_0000;

    // Build a read frame for the poll loop.
    function automatic logic [31:0] poll_frame(input logic [4:0] phy, input logic [4:0] rad);
        return {2'b01, 2'b10, phy, rad, 2'b10, 16'h0000};
    endfunction
endpackage

// File: rtl/mdio_serdes.sv
// Serial frame engine: sends a 32-one preamble and a 32-bit frame on MDC/MDIO,
// releases MDIO after the read header and samples 16 read data bits.
// Assumes start is only raised while busy is low.
module mdio_serdes #(
    parameter int CLK_HALF = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [31:0] frame_in,
    input  logic        din,
    output logic        busy,
    output logic        done,
    output logic [15:0] rdata,
    output logic        mdc,
    output logic        dout,
    output logic        doe
);
    localparam int PH_W = (2 * CLK_HALF > 2) ? $clog2(2 * CLK_HALF) : 1;
    localparam logic [PH_W-1:0] PH_MID  = PH_W'(CLK_HALF);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(2 * CLK_HALF - 1);

    logic [PH_W-1:0] ph;
    logic [5:0]      idx;
    logic [31:0]     frm;
    logic            rd_op;

    assign rd_op = (frm[29:28] == 2'b10);

    // Bit sequencer: phase counter inside a bit time, bit index over 64 bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            ph    <= '0;
            idx   <= '0;
            frm   <= '0;
            rdata <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy <= 1'b1;
                    ph   <= '0;
                    idx  <= '0;
                    frm  <= frame_in;
                end
            end else begin
                if (ph == PH_MID && idx >= 6'd48 && rd_op)
                    rdata <= {rdata[14:0], din};
                if (ph == PH_LAST) begin
                    ph <= '0;
                    if (idx == 6'd63) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        idx <= idx + 6'd1;
                    end
                end else begin
                    ph <= ph + 1'b1;
                end
            end
        end
    end

    // Pin values: clock high in the second half, preamble ones, then frame MSB first.
    always_comb begin
        mdc  = busy && (ph >= PH_MID);
        dout = (idx < 6'd32) ? 1'b1 : frm[~idx[4:0]];
        doe  = busy && (!rd_op || idx < 6'd46);
    end
endmodule

// File: rtl/mdio_poll_track.sv
// Poll result tracker: holds the last polled value, gathers changed bits and
// forms the masked interrupt level. Assumes upd pulses once per finished poll.
module mdio_poll_track #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic         upd,
    input  logic [W-1:0] val,
    input  logic         clr,
    input  logic [W-1:0] mask,
    output logic [W-1:0] basic,
    output logic [W-1:0] changed,
    output logic         irq
);
    logic primed;

    // Value and change-set update; a same-cycle change wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            primed  <= 1'b0;
            basic   <= '0;
            changed <= '0;
        end else begin
            if (!enable)
                primed <= 1'b0;
            else if (upd)
                primed <= 1'b1;
            if (upd)
                basic <= val;
            changed <= (clr ? '0 : changed) | ((upd && primed) ? (basic ^ val) : '0);
        end
    end

    // Interrupt when any unmasked change is present.
    assign irq = |(changed & ~mask);
endmodule

// File: rtl/mdio_pin_mux.sv
// Pin steering: picks bit-bang or engine values and routes the output enable
// and input sampling to the selected port. Assumes exactly two ports.
module mdio_pin_mux #(
    parameter int PORTS = 2
) (
    input  logic             bb_en,
    input  logic             sel,
    input  logic             bb_clk,
    input  logic             bb_dat,
    input  logic             bb_oe,
    input  logic             e_mdc,
    input  logic             e_dout,
    input  logic             e_doe,
    input  logic [PORTS-1:0] pin_in,
    output logic             mdc,
    output logic             dout,
    output logic [PORTS-1:0] oe,
    output logic             din
);
    logic oe_any;

    // Source choice between bit-bang registers and the engine.
    always_comb begin
        mdc    = bb_en ? bb_clk : e_mdc;
        dout   = bb_en ? bb_dat : e_dout;
        oe_any = bb_en ? bb_oe  : e_doe;
        din    = pin_in[sel];
    end

    // One enable per port, only the selected one may rise.
    for (genvar g = 0; g < PORTS; g++) begin : g_oe
        assign oe[g] = oe_any && (sel == g[0]);
    end
endmodule

// File: rtl/mdio_mgmt.sv
// MDIO management top: register file, host/poll arbitration, frame engine,
// poll tracker and pin steering. Assumes reg_wr and reg_rd are not raised
// together and that reg_rdata is sampled in the reg_rd cycle.
module mdio_mgmt
    import mdio_pkg::*;
#(
    parameter int CLK_HALF = 2,
    parameter int DW       = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_out,
    output logic [1:0]  mdio_oe,
    input  logic [1:0]  mdio_in,
    output logic        irq
);
    logic [31:0] frame_q;
    logic [14:0] cfg_q;
    logic [DW-1:0] mask_q;
    logic        bb_clk_q, bb_dat_q, bb_oe_q;
    logic        host_pend, own_host;

    logic        cfg_sel, cfg_poll, cfg_bb;
    logic [4:0]  cfg_preg, cfg_pphy;
    logic        eng_busy, eng_done, e_mdc, e_dout, e_doe, pin_din;
    logic [15:0] eng_rdata;
    logic        start_host, start_poll, poll_upd, stat_rd;
    logic [DW-1:0] p_basic, p_changed;

    assign cfg_sel  = cfg_q[0];
    assign cfg_poll = cfg_q[1];
    assign cfg_bb   = cfg_q[2];
    assign cfg_preg = cfg_q[7:3];
    assign cfg_pphy = cfg_q[14:10];

    assign start_host = !eng_busy && !cfg_bb && host_pend;
    assign start_poll = !eng_busy && !cfg_bb && !host_pend && cfg_poll;
    assign poll_upd   = eng_done && !own_host;
    assign stat_rd    = reg_rd && (reg_addr == RA_STAT);

    // Host registers and frame completion write-back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q   <= FRAME_IDLE;
            cfg_q     <= '0;
            mask_q    <= '1;
            bb_clk_q  <= 1'b0;
            bb_dat_q  <= 1'b0;
            bb_oe_q   <= 1'b0;
            host_pend <= 1'b0;
            own_host  <= 1'b0;
        end else begin
            if (start_host) begin
                host_pend <= 1'b0;
                own_host  <= 1'b1;
            end else if (start_poll) begin
                own_host  <= 1'b0;
            end
            if (eng_done && own_host) begin
                frame_q[16] <= 1'b1;
                if (frame_q[29:28] == 2'b10)
                    frame_q[15:0] <= eng_rdata;
            end
            if (reg_wr) begin
                case (reg_addr)
                    RA_FRAME: begin
                        frame_q   <= reg_wdata & ~32'h0001_0000;
                        host_pend <= 1'b1;
                    end
                    RA_CFG:   cfg_q    <= reg_wdata[14:0] & 15'h7CFF;
                    RA_MASK:  mask_q   <= reg_wdata[DW-1:0];
                    RA_BBCLK: bb_clk_q <= reg_wdata[0];
                    RA_BBDAT: bb_dat_q <= reg_wdata[0];
                    RA_BBOE:  bb_oe_q  <= reg_wdata[0];
                    default: ;
                endcase
            end
        end
    end

    // Read data selection.
    always_comb begin
        case (reg_addr)
            RA_FRAME: reg_rdata = frame_q;
            RA_CFG:   reg_rdata = {17'h0, cfg_q};
            RA_MASK:  reg_rdata = {{(32-DW){1'b0}}, mask_q};
            RA_STAT:  reg_rdata = {p_basic, p_changed};
            RA_BBCLK: reg_rdata = {31'h0, bb_clk_q};
            RA_BBDAT: reg_rdata = {31'h0, pin_din};
            RA_BBOE:  reg_rdata = {31'h0, bb_oe_q};
            default:  reg_rdata = '0;
        endcase
    end

    mdio_serdes #(.CLK_HALF(CLK_HALF)) u_serdes (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start_host || start_poll),
        .frame_in (start_host ? frame_q : poll_frame(cfg_pphy, cfg_preg)),
        .din      (pin_din),
        .busy     (eng_busy),
        .done     (eng_done),
        .rdata    (eng_rdata),
        .mdc      (e_mdc),
        .dout     (e_dout),
        .doe      (e_doe)
    );

    mdio_poll_track #(.W(DW)) u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (cfg_poll && !cfg_bb),
        .upd     (poll_upd),
        .val     (eng_rdata[DW-1:0]),
        .clr     (stat_rd),
        .mask    (mask_q),
        .basic   (p_basic),
        .changed (p_changed),
        .irq     (irq)
    );

    mdio_pin_mux #(.PORTS(2)) u_pins (
        .bb_en  (cfg_bb),
        .sel    (cfg_sel),
        .bb_clk (bb_clk_q),
        .bb_dat (bb_dat_q),
        .bb_oe  (bb_oe_q),
        .e_mdc  (e_mdc),
        .e_dout (e_dout),
        .e_doe  (e_doe),
        .pin_in (mdio_in),
        .mdc    (mdc),
        .dout   (mdio_out),
        .oe     (mdio_oe),
        .din    (pin_din)
    );
endmodule

// File: rtl/mdio_mgmt_chk.sv
// Property checker for mdio_mgmt, attached by bind. Observes pins and
// internal hand-off signals between the register file and the engine.
module mdio_mgmt_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        eng_busy,
    input logic        own_host,
    input logic [31:0] frame_q,
    input logic        cfg_bb,
    input logic        bb_clk_q,
    input logic        mdc,
    input logic [1:0]  mdio_oe,
    input logic        stat_rd,
    input logic        poll_upd,
    input logic        reg_wr,
    input logic        irq
);
    // R3: completion bit stays low while a host frame is on the wire.
    p_ta_low_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_busy && own_host) |-> !frame_q[16]);

    // R4: clock idles low when neither engine nor bit-bang drives it.
    p_mdc_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!eng_busy && !cfg_bb) |-> !mdc);

    // R9: a status read with no poll result in that cycle leaves irq low next cycle.
    p_clear_drops_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !poll_upd && !reg_wr) |=> !irq);

    // R10: in bit-bang mode the clock pin follows its register.
    p_bb_clk_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_bb |-> (mdc == bb_clk_q));

    // R12: never more than one port enabled.
    p_oe_onehot_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mdio_oe));
endmodule

bind mdio_mgmt mdio_mgmt_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .eng_busy (eng_busy),
    .own_host (own_host),
    .frame_q  (frame_q),
    .cfg_bb   (cfg_bb),
    .bb_clk_q (bb_clk_q),
    .mdc      (mdc),
    .mdio_oe  (mdio_oe),
    .stat_rd  (stat_rd),
    .poll_upd (poll_upd),
    .reg_wr   (reg_wr),
    .irq      (irq)
);

// File: tb/mdio_mgmt_test.sv
// Directed bench for mdio_mgmt with a PHY responder decoding 64-bit frames.
module mdio_mgmt_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_out, irq;
    logic [1:0]  mdio_oe, mdio_in;

    int n_chk = 0, n_bad = 0, wd = 0;

    // Responder state
    int          bitn = 0, nframes = 0, oe_err = 0;
    logic [31:0] cap = '0, last_frame = '0, prev_frame = '0;
    logic [15:0] phy_val = 16'h0;
    logic        drv = 1'b1, sel_b = 1'b0, bb_phase = 1'b0, bb_pin = 1'b0;
    logic [1:0]  oe_seen = '0;

    always #2 clk = ~clk;

    mdio_mgmt #(.CLK_HALF(2), .DW(16)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in),
        .irq(irq)
    );

    assign mdio_in = bb_phase ? {1'b0, bb_pin} : (sel_b ? {drv, 1'b0} : {1'b0, drv});

    // Responder: capture driven bits on MDC rise, log each complete frame.
    always @(posedge mdc) if (!bb_phase) begin
        oe_seen = oe_seen | mdio_oe;
        if (bitn >= 46 && cap[29:28] == 2'b10 && mdio_oe != 2'b00) oe_err++;
        if (bitn >= 36 && cap[29:28] != 2'b10 && mdio_oe == 2'b00) oe_err++;
        if (bitn >= 32) cap[63-bitn] = mdio_out;
        if (bitn == 63) begin
            prev_frame = last_frame;
            last_frame = cap;
            nframes++;
            bitn = 0;
        end else bitn++;
    end

    // Responder: drive read data on MDC fall for the next bit.
    always @(negedge mdc) if (!bb_phase) begin
        if (bitn >= 48 && cap[29:28] == 2'b10) drv = phy_val[63-bitn];
        else drv = 1'b1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_frames(input int n);
        int target = nframes + n;
        while (nframes < target) @(negedge clk);
        repeat (8) @(negedge clk);
    endtask

    task automatic wait_done();
        logic [31:0] d;
        for (int i = 0; i < 2000; i++) begin
            rd(3'd0, d);
            if (d[16]) return;
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(3'd0, d); check("R3 reset frame", d, 32'h0001_0000);
        rd(3'd3, d); check("R7 reset status", d, 32'h0);
        rd(3'd2, d); check("R8 reset mask", d, 32'h0000_FFFF);
        check("R4 idle mdc", {31'h0, mdc}, 32'h0);
        check("R12 idle oe", {30'h0, mdio_oe}, 32'h0);
    endtask

    task automatic t_host_write();
        logic [31:0] d, f;
        realtime t0;
        f = {2'b01, 2'b01, 5'd5, 5'd3, 2'b10, 16'hA5C3};
        oe_err = 0;
        wr(3'd0, f);
        rd(3'd0, d); check("R3 bit16 clear on write", {31'h0, d[16]}, 32'h0);
        @(posedge mdc); t0 = $realtime;
        @(posedge mdc);
        check("R4 mdc period ns", 32'($realtime - t0), 32'd16);
        wait_done();
        check("R2 write frame on wire", last_frame, f);
        check("R2 enable held all bits", 32'(oe_err), 32'h0);
        rd(3'd0, d); check("R3 bit16 set on done", {31'h0, d[16]}, 32'h1);
    endtask

    task automatic t_host_read();
        logic [31:0] d, f;
        phy_val = 16'h1234;
        f = {2'b01, 2'b10, 5'd2, 5'd1, 2'b00, 16'h0};
        oe_err = 0;
        wr(3'd0, f);
        wait_done();
        rd(3'd0, d);
        check("R1 read data and done", {d[31:16], d[15:0]}, {f[31:17], 1'b1, 16'h1234});
        check("R1 read header on wire", {18'h0, last_frame[31:18]}, {18'h0, f[31:18]});
        check("R5 enable released", 32'(oe_err), 32'h0);
    endtask

    task automatic t_phy_sel();
        logic [31:0] d;
        wr(3'd1, 32'h1);
        sel_b = 1'b1; phy_val = 16'hBEEF; oe_seen = '0;
        wr(3'd0, {2'b01, 2'b10, 5'd1, 5'd2, 2'b00, 16'h0});
        wait_done();
        rd(3'd0, d);
        check("R12 sampled selected port", {16'h0, d[15:0]}, 32'h0000_BEEF);
        check("R12 enable on port 1 only", {30'h0, oe_seen}, 32'h2);
        wr(3'd1, 32'h0);
        sel_b = 1'b0;
    endtask

    task automatic t_poll();
        logic [31:0] d;
        phy_val = 16'h0F0F;
        wr(3'd2, 32'hFFFF);
        wr(3'd1, {17'h0, 5'd9, 2'b00, 5'd7, 3'b010});
        wait_frames(2);
        check("R6 poll header", {18'h0, last_frame[31:18]}, {18'h0, 2'b01, 2'b10, 5'd9, 5'd7});
        rd(3'd3, d); check("R7 steady value no change", d, 32'h0F0F_0000);
        check("R8 irq low steady", {31'h0, irq}, 32'h0);
        wait_frames(1);
        phy_val = 16'h0F0A;
        wait_frames(2);
        check("R8 masked change no irq", {31'h0, irq}, 32'h0);
        wr(3'd2, 32'hFFFE);
        check("R8 unmasked change irq", {31'h0, irq}, 32'h1);
        rd(3'd3, d); check("R7 changed bits", d, 32'h0F0A_0005);
        check("R9 irq dropped after read", {31'h0, irq}, 32'h0);
        rd(3'd3, d); check("R9 changed cleared", {16'h0, d[15:0]}, 32'h0);
    endtask

    task automatic t_host_during_poll();
        logic [31:0] f, d;
        int base;
        f = {2'b01, 2'b01, 5'd4, 5'd31, 2'b10, 16'h7777};
        while (bitn != 10) @(negedge clk);
        base = nframes;
        wr(3'd0, f);
        rd(3'd0, d); check("R11 host pending", {31'h0, d[16]}, 32'h0);
        while (nframes < base + 1) @(negedge clk);
        check("R11 running poll finishes first", {18'h0, last_frame[31:18]}, {18'h0, 2'b01, 2'b10, 5'd9, 5'd7});
        while (nframes < base + 2) @(negedge clk);
        check("R11 host frame next", last_frame, f);
        wait_done();
    endtask

    task automatic t_bitbang();
        logic [31:0] d, f;
        int base;
        wr(3'd1, 32'h0);
        wait_frames(1);
        repeat (300) @(negedge clk);
        bb_phase = 1'b1;
        wr(3'd1, 32'h4);
        wr(3'd4, 32'h1); wr(3'd5, 32'h1); wr(3'd6, 32'h1);
        check("R10 pins follow registers", {29'h0, mdc, mdio_out, mdio_oe[0]}, 32'h7);
        check("R10 port 1 not enabled", {31'h0, mdio_oe[1]}, 32'h0);
        bb_pin = 1'b1; rd(3'd5, d); check("R10 data read from pin", d, 32'h1);
        bb_pin = 1'b0; rd(3'd5, d); check("R10 data read from pin low", d, 32'h0);
        wr(3'd5, 32'h0);
        check("R10 data pin follows", {31'h0, mdio_out}, 32'h0);
        f = {2'b01, 2'b01, 5'd6, 5'd6, 2'b10, 16'h3C3C};
        wr(3'd1, {17'h0, 5'd9, 2'b00, 5'd7, 3'b110});
        wr(3'd0, f);
        repeat (600) @(negedge clk);
        rd(3'd0, d); check("R10 host frame held", {31'h0, d[16]}, 32'h0);
        wr(3'd4, 32'h0); wr(3'd6, 32'h0);
        base = nframes;
        bitn = 0;
        bb_phase = 1'b0;
        wr(3'd1, {17'h0, 5'd9, 2'b00, 5'd7, 3'b010});
        while (nframes < base + 1) @(negedge clk);
        check("R11 host before poll after release", last_frame, f);
        wait_done();
        rd(3'd0, d); check("R3 held frame completes", {31'h0, d[16]}, 32'h1);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_host_write();
        t_host_read();
        t_phy_sel();
        t_poll();
        t_host_during_poll();
        t_bitbang();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule